// File: doc/BRIEF.md
# Tri-State PWM Input and Start-Up Overvoltage Supervisor

This block sits ahead of a gate sequencer in a synchronous buck power stage. It turns five digital status flags into three commands for the sequencer: a request to hold both gates off, a request to hold the low-side gate on, and a clean PWM level. The flags are a supply-good indication, an enable, two window comparator results for the PWM pin (below the low threshold, above the high threshold) and a switch-node overvoltage flag. The PWM can be driven to a mid level by the controller. A mid level that is held long enough is read as a third state, in which both gates are off.

The mode machine has four states. S_OFF means the supply is not good or enable is low. S_HIZ means both gates are off because the PWM is parked in the window. S_OVP means the low-side gate is latched on after an overvoltage. S_RUN means the PWM level is passed through. The transitions are as follows. Power-up (S_OFF to S_HIZ) happens when the supply is good and enable is high. Release (S_HIZ to S_RUN) happens on a below-threshold sample. Trip (S_HIZ to S_OVP) happens on an overvoltage while protection is armed. Hand-back (S_OVP to S_RUN) happens on any sample outside the window. Park (S_RUN to S_HIZ) happens when the window hold-off expires. Shutdown (any state to S_OFF) happens when the supply drops or enable falls. Protection is armed while the supply is low. It is disarmed by the first release or hand-back.

Top module: `drv_mode_supervisor`

## Requirements
- R1: While `uvlo_ok_i` is low, the next cycle shows `force_off_o`=1, `force_ls_on_o`=0 and `pwm_level_o`=0, whatever the other inputs are, including when the low-side latch was active.
- R2: While `en_i` is low, the next cycle shows `force_off_o`=1 and `force_ls_on_o`=0, whatever the PWM flags are.
- R3: From S_OFF, with `uvlo_ok_i` and `en_i` both high, the block enters S_HIZ one cycle later, with `force_off_o`=1.
- R4: The three comparator flags pass through a two-flop synchroniser. A PWM flag change applied before clock edge k shows on the outputs after edge k+2, and not after edge k+1.
- R5: In S_RUN, `pwm_level_o` is 0 when the below flag is set (also when both flags are set), 1 when only the above flag is set, and keeps its last value while neither flag is set.
- R6: In S_RUN, HOLDOFF_CYCLES consecutive in-window samples move the block to S_HIZ. Any out-of-window sample restarts the count.
- R7: In S_HIZ, the above flag has no effect. Only a below sample leaves the state, and it leaves to S_RUN with level 0.
- R8: In S_HIZ with protection armed, a sampled overvoltage gives `force_ls_on_o`=1 and `force_off_o`=0. This stays set after the overvoltage flag clears.
- R9: S_OVP is left for S_RUN on a below sample (level 0) or on an above sample (level 1).
- R10: After the first release or hand-back, overvoltage is ignored in S_HIZ until `uvlo_ok_i` has been low again. A fall of `en_i` does not re-arm it.
- R11: When a below sample and an overvoltage sample reach S_HIZ in the same cycle, the release wins and the low-side latch is not set.
- R12: `force_off_o` and `force_ls_on_o` are never high together, and `pwm_level_o` is high only in S_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_ok_i | input | 1 | Supply above its undervoltage threshold |
| en_i | input | 1 | Driver enable |
| pwm_below_i | input | 1 | PWM below the low threshold (asynchronous) |
| pwm_above_i | input | 1 | PWM above the high threshold (asynchronous) |
| sw_ov_i | input | 1 | Switch-node overvoltage (asynchronous) |
| force_off_o | output | 1 | Sequencer must hold both gates off |
| force_ls_on_o | output | 1 | Sequencer must hold the low-side gate on |
| pwm_level_o | output | 1 | Decoded PWM level for the sequencer |

## Verification
The release on a below sample and the overvoltage trip can both be decided in the same S_HIZ cycle. The bench raises the below flag and the overvoltage flag together on one falling clock edge, so both reach the state machine after the same synchroniser delay. The result is judged by the release: S_RUN with level 0 and no low-side request on that cycle and on later ones. The bench also drops the supply while the latch holds, to show that shutdown wins over the latch.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;
    typedef enum logic [1:0] {
        S_OFF = 2'd0,
        S_HIZ = 2'd1,
        S_OVP = 2'd2,
        S_RUN = 2'd3
    } sup_state_t;

    localparam int FLAG_BELOW = 0;
    localparam int FLAG_ABOVE = 1;
    localparam int FLAG_OV    = 2;
    localparam int FLAG_COUNT = 3;
endpackage

// File: rtl/sup_sync.sv
`timescale 1ns/1ps
module sup_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] shreg;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shreg <= '0;
            end else begin
                shreg <= {shreg[STAGES-2:0], async_i[b]};
            end
        end
        assign sync_o[b] = shreg[STAGES-1];
    end
endmodule

// File: rtl/sup_holdoff.sv
`timescale 1ns/1ps
module sup_holdoff #(
    parameter int HOLDOFF_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en_i,
    output logic expire_o
);
    localparam int CW = (HOLDOFF_CYCLES > 1) ? $clog2(HOLDOFF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign expire_o = count_en_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!count_en_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sup_ov_arm.sv
`timescale 1ns/1ps
module sup_ov_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic uvlo_ok_i,
    input  logic disarm_i,
    output logic armed_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_o <= 1'b1;
        end else if (!uvlo_ok_i) begin
            armed_o <= 1'b1;
        end else if (disarm_i) begin
            armed_o <= 1'b0;
        end
    end
endmodule

// File: rtl/drv_mode_supervisor.sv
`timescale 1ns/1ps
module drv_mode_supervisor
    import sup_pkg::*;
#(
    parameter int HOLDOFF_CYCLES = 8,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uvlo_ok_i,
    input  logic en_i,
    input  logic pwm_below_i,
    input  logic pwm_above_i,
    input  logic sw_ov_i,
    output logic force_off_o,
    output logic force_ls_on_o,
    output logic pwm_level_o
);
    logic [FLAG_COUNT-1:0] flags_async;
    logic [FLAG_COUNT-1:0] flags_sync;
    logic below_s;
    logic above_s;
    logic ovp_s;
    logic in_window;
    logic hold_expire;
    logic ov_armed;
    logic disarm;

    sup_state_t state_q;
    sup_state_t state_d;
    logic       lvl_q;
    logic       lvl_d;

    assign flags_async[FLAG_BELOW] = pwm_below_i;
    assign flags_async[FLAG_ABOVE] = pwm_above_i;
    assign flags_async[FLAG_OV]    = sw_ov_i;

    sup_sync #(
        .WIDTH (FLAG_COUNT),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(flags_async),
        .sync_o (flags_sync)
    );

    assign below_s   = flags_sync[FLAG_BELOW];
    assign above_s   = flags_sync[FLAG_ABOVE];
    assign ovp_s     = flags_sync[FLAG_OV];
    assign in_window = !below_s && !above_s;

    sup_holdoff #(
        .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
    ) u_holdoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en_i(state_q == S_RUN && in_window),
        .expire_o  (hold_expire)
    );

    sup_ov_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .uvlo_ok_i(uvlo_ok_i),
        .disarm_i (disarm),
        .armed_o  (ov_armed)
    );

    // next-state and level decode
    always_comb begin
        state_d = state_q;
        if (!uvlo_ok_i || !en_i) begin
            state_d = S_OFF;                       // shutdown
        end else begin
            unique case (state_q)
                S_OFF: state_d = S_HIZ;            // power-up
                S_HIZ: begin
                    if (below_s) begin
                        state_d = S_RUN;           // release (wins over trip)
                    end else if (ovp_s && ov_armed) begin
                        state_d = S_OVP;           // trip
                    end
                end
                S_OVP: begin
                    if (below_s || above_s) begin
                        state_d = S_RUN;           // hand-back
                    end
                end
                S_RUN: begin
                    if (hold_expire) begin
                        state_d = S_HIZ;           // park
                    end
                end
                default: state_d = S_OFF;
            endcase
        end

        if (state_d == S_RUN) begin
            if (below_s) begin
                lvl_d = 1'b0;
            end else if (above_s) begin
                lvl_d = 1'b1;
            end else begin
                lvl_d = lvl_q;
            end
        end else begin
            lvl_d = 1'b0;
        end

        disarm = (state_q == S_HIZ || state_q == S_OVP) && (state_d == S_RUN);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    // outputs
    always_comb begin
        force_off_o   = 1'b0;
        force_ls_on_o = 1'b0;
        pwm_level_o   = 1'b0;
        unique case (state_q)
            S_OFF:   force_off_o   = 1'b1;
            S_HIZ:   force_off_o   = 1'b1;
            S_OVP:   force_ls_on_o = 1'b1;
            S_RUN:   pwm_level_o   = lvl_q;
            default: force_off_o   = 1'b1;
        endcase
    end
endmodule

// File: rtl/sup_chk.sv
`timescale 1ns/1ps
module sup_chk
    import sup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       uvlo_ok_i,
    input logic       en_i,
    input logic       force_off_o,
    input logic       force_ls_on_o,
    input logic       pwm_level_o,
    input sup_state_t state_q,
    input logic       ov_armed,
    input logic       below_s,
    input logic       ovp_s
);
    // R12
    excl_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(force_off_o && force_ls_on_o));

    // R12
    level_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_level_o |-> (!force_off_o && !force_ls_on_o));

    // R1
    supply_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_ok_i |=> (force_off_o && !force_ls_on_o && !pwm_level_o));

    // R2
    enable_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (force_off_o && !force_ls_on_o));

    // R7
    hiz_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIZ && !below_s && !(ovp_s && ov_armed) && uvlo_ok_i && en_i)
            |=> (state_q == S_HIZ));

    // R8
    ov_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIZ && ovp_s && ov_armed && !below_s && uvlo_ok_i && en_i)
            |=> force_ls_on_o);

    // R10
    disarmed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIZ && !ov_armed) |=> !force_ls_on_o);

    // R11
    release_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIZ && below_s && uvlo_ok_i && en_i) |=> (state_q == S_RUN));
endmodule

bind drv_mode_supervisor sup_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .uvlo_ok_i    (uvlo_ok_i),
    .en_i         (en_i),
    .force_off_o  (force_off_o),
    .force_ls_on_o(force_ls_on_o),
    .pwm_level_o  (pwm_level_o),
    .state_q      (state_q),
    .ov_armed     (ov_armed),
    .below_s      (below_s),
    .ovp_s        (ovp_s)
);

// File: tb/tb_drv_mode_supervisor.sv
`timescale 1ns/1ps
module tb_drv_mode_supervisor;
    localparam int HOLD = 8;
    localparam int LCMP = 3;   // two synchroniser flops plus state register

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo_ok = 1'b0;
    logic en = 1'b0;
    logic below = 1'b0;
    logic above = 1'b0;
    logic ov = 1'b0;
    logic force_off;
    logic force_ls_on;
    logic pwm_level;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int    due;
        bit    fo;
        bit    ls;
        bit    lv;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    drv_mode_supervisor #(
        .HOLDOFF_CYCLES(HOLD),
        .SYNC_STAGES   (2)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .uvlo_ok_i    (uvlo_ok),
        .en_i         (en),
        .pwm_below_i  (below),
        .pwm_above_i  (above),
        .sw_ov_i      (ov),
        .force_off_o  (force_off),
        .force_ls_on_o(force_ls_on),
        .pwm_level_o  (pwm_level)
    );

    task automatic expect_at(int lat, bit fo, bit ls, bit lv, string tag);
        exp_t e;
        e.due = cyc + lat;
        e.fo  = fo;
        e.ls  = ls;
        e.lv  = lv;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic set_in(bit u, bit e, bit lo, bit hi, bit o);
        @(negedge clk);
        uvlo_ok = u;
        en      = e;
        below   = lo;
        above   = hi;
        ov      = o;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected items when their cycle arrives
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (force_off !== e.fo || force_ls_on !== e.ls || pwm_level !== e.lv) begin
                    n_bad++;
                    $display("FAIL %s: got off=%0b ls_on=%0b lvl=%0b expected off=%0b ls_on=%0b lvl=%0b",
                             e.tag, force_off, force_ls_on, pwm_level, e.fo, e.ls, e.lv);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        expect_at(1, 1, 0, 0, "R1 reset state off"); idle(1);

        // R1: supply low ignores enable and PWM
        set_in(0, 1, 0, 1, 0);
        expect_at(1, 1, 0, 0, "R1 supply low"); expect_at(4, 1, 0, 0, "R1 supply low held"); idle(4);

        // R3 power-up into hiz, R7 above ignored
        set_in(1, 1, 0, 1, 0);
        expect_at(1, 1, 0, 0, "R3 power-up hiz"); expect_at(6, 1, 0, 0, "R7 above ignored"); idle(6);

        // R8 trip and latch
        set_in(1, 1, 0, 0, 1);
        expect_at(2, 1, 0, 0, "R4 trip not yet"); expect_at(3, 0, 1, 0, "R8 trip"); idle(3);
        set_in(1, 1, 0, 0, 0);
        expect_at(5, 0, 1, 0, "R8 latched"); idle(5);

        // R9 hand-back on above
        set_in(1, 1, 0, 1, 0);
        expect_at(3, 0, 0, 1, "R9 hand-back above"); idle(3);

        // R5 level decode
        set_in(1, 1, 1, 0, 0);
        expect_at(3, 0, 0, 0, "R5 below"); idle(3);
        set_in(1, 1, 1, 1, 0);
        expect_at(3, 0, 0, 0, "R5 both flags"); idle(3);
        set_in(1, 1, 0, 1, 0);
        expect_at(3, 0, 0, 1, "R5 above"); idle(3);

        // R6 restart of the hold-off count
        set_in(1, 1, 0, 0, 0);
        idle(HOLD - 2);
        set_in(1, 1, 0, 1, 0);
        set_in(1, 1, 0, 0, 0);
        expect_at(3, 0, 0, 1, "R5 window holds level");
        expect_at(HOLD + 1, 0, 0, 1, "R6 count restarted");
        expect_at(HOLD + 2, 1, 0, 0, "R6 park after restart");
        idle(HOLD + 2);

        // R10 disarmed: overvoltage ignored in hiz
        set_in(1, 1, 0, 0, 1);
        expect_at(3, 1, 0, 0, "R10 ov ignored"); expect_at(6, 1, 0, 0, "R10 ov ignored held"); idle(6);
        set_in(1, 1, 1, 0, 0);
        expect_at(3, 0, 0, 0, "R7 release on below"); idle(3);

        // R2 enable low, then re-enable does not re-arm
        set_in(1, 0, 0, 1, 0);
        expect_at(1, 1, 0, 0, "R2 enable low"); expect_at(6, 1, 0, 0, "R2 enable low held"); idle(6);
        set_in(1, 1, 0, 0, 1);
        expect_at(1, 1, 0, 0, "R3 re-enable hiz"); expect_at(5, 1, 0, 0, "R10 not re-armed by enable"); idle(5);

        // re-arm through supply drop, then R11 same-cycle release and trip
        set_in(0, 1, 0, 0, 0);
        expect_at(1, 1, 0, 0, "R1 supply drop"); idle(3);
        set_in(1, 1, 0, 0, 0);
        expect_at(1, 1, 0, 0, "R3 hiz after supply"); idle(3);
        set_in(1, 1, 1, 0, 1);
        expect_at(3, 0, 0, 0, "R11 release wins"); expect_at(6, 0, 0, 0, "R11 no latch later"); idle(6);

        // R4 synchroniser latency
        set_in(1, 1, 0, 1, 0);
        expect_at(2, 0, 0, 0, "R4 level not yet"); expect_at(3, 0, 0, 1, "R4 level after sync"); idle(3);

        // R9 hand-back on below
        set_in(0, 1, 0, 0, 0);
        expect_at(1, 1, 0, 0, "R1 supply drop"); idle(3);
        set_in(1, 1, 0, 0, 0);
        expect_at(1, 1, 0, 0, "R3 hiz"); idle(3);
        set_in(1, 1, 0, 0, 1);
        expect_at(3, 0, 1, 0, "R8 trip re-armed"); idle(3);
        set_in(1, 1, 1, 0, 0);
        expect_at(3, 0, 0, 0, "R9 hand-back below"); idle(3);

        // R6 plain hold-off expiry
        set_in(1, 1, 0, 0, 0);
        expect_at(HOLD + 1, 0, 0, 0, "R6 before expiry");
        expect_at(HOLD + 2, 1, 0, 0, "R6 park on expiry");
        idle(HOLD + 2);

        // R1 supply drop overrides the latch
        set_in(0, 1, 0, 0, 0);
        expect_at(1, 1, 0, 0, "R1 supply drop"); idle(3);
        set_in(1, 1, 0, 0, 0);
        expect_at(1, 1, 0, 0, "R3 hiz"); idle(3);
        set_in(1, 1, 0, 0, 1);
        expect_at(3, 0, 1, 0, "R8 trip"); idle(3);
        set_in(0, 1, 0, 0, 1);
        expect_at(1, 1, 0, 0, "R1 drop during latch"); idle(3);

        if (!finished) begin
            finished = 1'b1;
            if (sb.size() != 0) begin
                n_bad++;
                $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
            end
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule